// File: doc/BRIEF.md
# Write/Read Sequencer for a Floating-Gate Word Memory

This controller stands between a tag baseband and a small multiple-time-programmable floating-gate array of 32 words of 16 bits. The baseband places a word address (and, for a write, the data) on the inputs, then pulses one command line for a single clock. While the controller is enabled and idle it takes the command and pulls its ready output low until the whole operation is over. Any command that arrives at another time has no effect.

A write runs in two phases. It first clears the selected word with all columns enabled. It then sets bits, with the columns enabled by the write data. Each phase switches the high-voltage pump on, waits until the pump reports that its level has been reached, and only then starts the phase timer. A fixed pump-off gap separates the two phases. If the pump does not report its level within a timeout, the operation stops, an error flag is raised, and ready returns. A read drives a read-control pulse of fixed length. While that pulse lasts, each data bit comes from comparing the currents on the bit's two read bitlines. All phase lengths are given in microseconds and converted to cycles through a clock-frequency parameter.

Top module: `nvm_seq_ctrl`

## Requirements
- R1: After reset, ready_o is 1 and err_o, erase_o, prog_o, pump_en_o, rd_ctl_o, row_sel_o, col_en_o and dout_o are all 0.
- R2: A command is taken only in a cycle where en_i is 1, ready_o is 1 and exactly one of rd_cmd_i / wr_cmd_i is 1. ready_o is 0 in the following cycle. A command while busy, with en_i at 0, or with both command lines high has no effect.
- R3: A write holds erase_o high and prog_o low. It then holds both low for GAP cycles. It then holds prog_o high and returns ready_o to 1 in the cycle after prog_o falls. erase_o and prog_o are never high together.
- R4: pump_en_o is high in every erase-phase and program-phase cycle and low during the gap and outside writes.
- R5: Each phase timer starts only after pump_ok_i is sampled 1. A phase whose pump level is first seen in its k-th cycle lasts k + N cycles, where N is ERASE (2000 µs) or PROG (default equal to ERASE) scaled by CLK_KHZ.
- R6: During the erase phase col_en_o is 16'hFFFF. During the program phase col_en_o equals wdata_i. During a read it is 16'hFFFF. In the gap and when idle it is 0.
- R7: A read holds rd_ctl_o high for exactly READ cycles (100 µs scaled), never enables the pump, and returns ready_o to 1 in the cycle after.
- R8: While rd_ctl_o is 1, dout_o[i] is 1 exactly when cur1_i field i (4 bits, at bits 4i+3:4i) is greater than cur0_i field i. Equal values give 0. dout_o is 0 whenever rd_ctl_o is 0.
- R9: If pump_ok_i is still 0 in the TMO-th cycle of a ramp, the operation ends with ready_o back at 1 and err_o at 1. A pump level seen in exactly that cycle still succeeds. err_o clears when the next command is taken.
- R10: While busy, row_sel_o is one-hot with bit addr_i set. When idle it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Controller enable |
| rd_cmd_i | input | 1 | Read command pulse |
| wr_cmd_i | input | 1 | Write command pulse |
| addr_i | input | 5 | Word address, held for the whole operation |
| wdata_i | input | 16 | Write data, held for the whole operation |
| pump_ok_i | input | 1 | Pump high-voltage level reached |
| cur1_i | input | 64 | Sensed "1" bitline currents, 4 bits per column |
| cur0_i | input | 64 | Sensed "0" bitline currents, 4 bits per column |
| ready_o | output | 1 | Idle and able to take a command |
| err_o | output | 1 | Last operation ended by pump timeout |
| erase_o | output | 1 | Erase phase active |
| prog_o | output | 1 | Program phase active |
| pump_en_o | output | 1 | Charge pump enable |
| rd_ctl_o | output | 1 | Read-control pulse |
| row_sel_o | output | 32 | One-hot word select |
| col_en_o | output | 16 | Column enables |
| dout_o | output | 16 | Read data |

## Verification
Writes are run with several pump rise delays, so that phase lengths that grow with the rise time can be told apart from a timer that starts at pump enable. The rise delay is also placed exactly on the timeout limit and one cycle past it, which separates an off-by-one timeout from a correct one. Reads are run with current patterns that contain greater, equal and smaller pairs in both orientations, which exposes a swapped comparison or a greater-or-equal compare. Commands are issued while busy, while disabled and on both lines together, and the phase lengths and outputs that follow are compared with undisturbed runs.

// File: rtl/nvm_seq_pkg.sv
`timescale 1ns/1ps
package nvm_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ER_RAMP, ST_ER_RUN, ST_GAP, ST_PG_RAMP, ST_PG_RUN, ST_RD
  } seq_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/nvm_seq_fsm.sv
`timescale 1ns/1ps
module nvm_seq_fsm
  import nvm_seq_pkg::*;
#(
  parameter int ERASE_CYC = 2000,
  parameter int PROG_CYC  = 2000,
  parameter int GAP_CYC   = 200,
  parameter int READ_CYC  = 100,
  parameter int TMO_CYC   = 120
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_wr,
  input  logic       start_rd,
  input  logic       pump_ok,
  output seq_state_e state_o,
  output logic       timeout_o
);
  localparam int MAXC = max2(max2(max2(ERASE_CYC, PROG_CYC), max2(GAP_CYC, READ_CYC)), TMO_CYC);
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] E_LAST = CNT_W'(ERASE_CYC - 1);
  localparam logic [CNT_W-1:0] P_LAST = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] G_LAST = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] R_LAST = CNT_W'(READ_CYC - 1);
  localparam logic [CNT_W-1:0] T_LAST = CNT_W'(TMO_CYC - 1);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             to_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q + 1'b1;
    to_d  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (start_wr)      st_d = ST_ER_RAMP;
        else if (start_rd) st_d = ST_RD;
      end
      ST_ER_RAMP, ST_PG_RAMP: begin
        if (pump_ok) begin
          st_d  = (st_q == ST_ER_RAMP) ? ST_ER_RUN : ST_PG_RUN;
          cnt_d = '0;
        end else if (cnt_q == T_LAST) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
          to_d  = 1'b1;
        end
      end
      ST_ER_RUN: if (cnt_q == E_LAST) begin st_d = ST_GAP;     cnt_d = '0; end
      ST_GAP:    if (cnt_q == G_LAST) begin st_d = ST_PG_RAMP; cnt_d = '0; end
      ST_PG_RUN: if (cnt_q == P_LAST) begin st_d = ST_IDLE;    cnt_d = '0; end
      ST_RD:     if (cnt_q == R_LAST) begin st_d = ST_IDLE;    cnt_d = '0; end
      default: begin st_d = ST_IDLE; cnt_d = '0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o   = st_q;
  assign timeout_o = to_d;

  // R5: a ramp without the pump level never enters its timed phase
  assert_run_needs_pump_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_ER_RAMP || st_q == ST_PG_RAMP) && !pump_ok) |=>
      (st_q != ST_ER_RUN && st_q != ST_PG_RUN));

  // R3: program ramp is reached only through the gap
  assert_prog_after_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PG_RAMP) |-> ($past(st_q) == ST_GAP || $past(st_q) == ST_PG_RAMP));
endmodule

// File: rtl/nvm_row_dec.sv
`timescale 1ns/1ps
module nvm_row_dec #(
  parameter int ADDR_W = 5,
  localparam int ROWS  = 1 << ADDR_W
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic [ROWS-1:0]   rows
);
  for (genvar g = 0; g < ROWS; g++) begin : g_row
    assign rows[g] = en && (addr == ADDR_W'(g));
  end
endmodule

// File: rtl/nvm_sense.sv
`timescale 1ns/1ps
module nvm_sense #(
  parameter int COLS  = 16,
  parameter int CUR_W = 4
) (
  input  logic [COLS*CUR_W-1:0] cur1,
  input  logic [COLS*CUR_W-1:0] cur0,
  output logic [COLS-1:0]       bits
);
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign bits[c] = cur1[c*CUR_W +: CUR_W] > cur0[c*CUR_W +: CUR_W];
  end
endmodule

// File: rtl/nvm_seq_ctrl.sv
`timescale 1ns/1ps
module nvm_seq_ctrl
  import nvm_seq_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 16,
  parameter int CUR_W    = 4,
  parameter int CLK_KHZ  = 1000,
  parameter int ERASE_US = 2000,
  parameter int PROG_US  = ERASE_US,
  parameter int GAP_US   = 200,
  parameter int READ_US  = 100,
  parameter int TMO_US   = 120,
  localparam int ROWS      = 1 << ADDR_W,
  localparam int ERASE_CYC = CLK_KHZ * ERASE_US / 1000,
  localparam int PROG_CYC  = CLK_KHZ * PROG_US / 1000,
  localparam int GAP_CYC   = CLK_KHZ * GAP_US / 1000,
  localparam int READ_CYC  = CLK_KHZ * READ_US / 1000,
  localparam int TMO_CYC   = CLK_KHZ * TMO_US / 1000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_i,
  input  logic                    rd_cmd_i,
  input  logic                    wr_cmd_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic                    pump_ok_i,
  input  logic [DATA_W*CUR_W-1:0] cur1_i,
  input  logic [DATA_W*CUR_W-1:0] cur0_i,
  output logic                    ready_o,
  output logic                    err_o,
  output logic                    erase_o,
  output logic                    prog_o,
  output logic                    pump_en_o,
  output logic                    rd_ctl_o,
  output logic [ROWS-1:0]         row_sel_o,
  output logic [DATA_W-1:0]       col_en_o,
  output logic [DATA_W-1:0]       dout_o
);
  seq_state_e        state;
  logic              timeout, accept, err_q, err_d;
  logic [DATA_W-1:0] sensed;

  assign accept = en_i && (state == ST_IDLE) && (rd_cmd_i ^ wr_cmd_i);

  nvm_seq_fsm #(
    .ERASE_CYC(ERASE_CYC), .PROG_CYC(PROG_CYC), .GAP_CYC(GAP_CYC),
    .READ_CYC(READ_CYC), .TMO_CYC(TMO_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .start_wr(accept && wr_cmd_i), .start_rd(accept && rd_cmd_i),
    .pump_ok(pump_ok_i), .state_o(state), .timeout_o(timeout)
  );

  always_comb begin
    err_d = err_q;
    if (accept)       err_d = 1'b0;
    else if (timeout) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign ready_o   = (state == ST_IDLE);
  assign err_o     = err_q;
  assign erase_o   = (state == ST_ER_RAMP) || (state == ST_ER_RUN);
  assign prog_o    = (state == ST_PG_RAMP) || (state == ST_PG_RUN);
  assign pump_en_o = erase_o || prog_o;
  assign rd_ctl_o  = (state == ST_RD);

  nvm_row_dec #(.ADDR_W(ADDR_W)) u_rows (
    .en(!ready_o), .addr(addr_i), .rows(row_sel_o)
  );

  always_comb begin
    col_en_o = '0;
    if (erase_o || rd_ctl_o) col_en_o = '1;
    else if (prog_o)         col_en_o = wdata_i;
  end

  nvm_sense #(.COLS(DATA_W), .CUR_W(CUR_W)) u_sense (
    .cur1(cur1_i), .cur0(cur0_i), .bits(sensed)
  );

  assign dout_o = rd_ctl_o ? sensed : '0;

  // R2: a taken command makes the block busy in the next cycle
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && ready_o && (rd_cmd_i ^ wr_cmd_i)) |=> !ready_o);
  // R3: erase, program and read-control are mutually exclusive
  assert_phase_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_o, prog_o, rd_ctl_o}));
  // R3: end of the program phase is the end of the write
  assert_prog_end_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_o) |-> ready_o);
  // R10: exactly one row while busy, none while idle
  assert_row_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> $onehot(row_sel_o));
  assert_row_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (row_sel_o == '0));
  // R7: read never turns on the pump
  assert_read_no_pump_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctl_o |-> !pump_en_o);
endmodule

// File: tb/sim_nvm_seq_ctrl.sv
`timescale 1ns/1ps
module sim_nvm_seq_ctrl;
  localparam int CLK_KHZ = 100;
  localparam int E = 200, P = 200, G = 20, RD = 10, TMO = 12;

  logic        clk = 1'b0;
  logic        rst_n, en, rd, wr, pump_ok;
  logic [4:0]  addr;
  logic [15:0] wdata;
  logic [63:0] cur1, cur0;
  logic        ready, err, erase, prog, pump_en, rd_ctl;
  logic [31:0] row_sel;
  logic [15:0] col_en, dout;
  int          checks = 0, failures = 0, pump_delay = 5, pen_cnt = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  nvm_seq_ctrl #(.CLK_KHZ(CLK_KHZ)) u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en), .rd_cmd_i(rd), .wr_cmd_i(wr),
    .addr_i(addr), .wdata_i(wdata), .pump_ok_i(pump_ok), .cur1_i(cur1),
    .cur0_i(cur0), .ready_o(ready), .err_o(err), .erase_o(erase),
    .prog_o(prog), .pump_en_o(pump_en), .rd_ctl_o(rd_ctl),
    .row_sel_o(row_sel), .col_en_o(col_en), .dout_o(dout)
  );

  // pump model: level reached after pump_delay cycles of enable
  always @(posedge clk) pen_cnt <= pump_en ? pen_cnt + 1 : 0;
  assign pump_ok = pump_en && (pen_cnt >= pump_delay);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 0; en = 1; rd = 0; wr = 0; addr = 0; wdata = 0; cur1 = 0; cur0 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(ready && !err && !erase && !prog && !pump_en && !rd_ctl, "R1 ctrl",
          {ready, err, erase, prog, pump_en, rd_ctl}, 6'b100000);
    check(row_sel == 0 && col_en == 0 && dout == 0, "R1 buses", row_sel | col_en | dout, 0);
  endtask

  // write with optional disturbing commands while busy
  task automatic t_write(input logic [4:0] a, input logic [15:0] d, input int dly,
                         input bit disturb, input bit exp_to);
    int n = 0, ne = 0, np = 0, ng = 0, colbad = 0, rowbad = 0, rdseen = 0;
    int exp_total;
    pump_delay = dly;
    addr = a; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0;
    check(!ready, "R2 busy after write", ready, 0);
    while (!ready && n < 2000) begin
      if (erase) ne++;
      if (prog) np++;
      if (!pump_en) ng++;
      if (rd_ctl) rdseen++;
      if (erase && col_en != 16'hFFFF) colbad++;
      if (prog && col_en != d) colbad++;
      if (!pump_en && col_en != 0) colbad++;
      if (row_sel != (32'd1 << a)) rowbad++;
      if (disturb && (n == 3 || n == E + 10)) begin rd = 1; wr = 1; end
      else begin rd = 0; wr = 0; end
      @(negedge clk);
      n++;
    end
    rd = 0; wr = 0;
    if (exp_to) begin
      check(ne == TMO && np == 0, "R9 timeout length", ne, TMO);
      check(err && ready, "R9 err raised", {err, ready}, 2'b11);
    end else begin
      exp_total = 2 * (dly + 1) + E + G + P;
      check(ne == dly + 1 + E, "R5 erase length", ne, dly + 1 + E);
      check(np == dly + 1 + P, "R5 program length", np, dly + 1 + P);
      check(ng == G, "R4 gap pump off", ng, G);
      check(n == exp_total, "R3 write total", n, exp_total);
      check(!err, "R9 no err", err, 0);
    end
    check(colbad == 0, "R6 columns", colbad, 0);
    check(rowbad == 0, "R10 row select", rowbad, 0);
    check(rdseen == 0, "R2 no read while busy", rdseen, 0);
    check(row_sel == 0 && !pump_en, "R10 idle after write", row_sel, 0);
  endtask

  task automatic t_read(input logic [4:0] a, input bit swap);
    int n = 0, bad = 0, pumped = 0;
    logic [15:0] exp_d;
    for (int i = 0; i < 16; i++) begin
      cur1[i*4 +: 4] = swap ? 4'(15 - i) : 4'(i);
      cur0[i*4 +: 4] = 4'd7;
      exp_d[i] = swap ? (15 - i > 7) : (i > 7);
    end
    addr = a; rd = 1;
    @(negedge clk);
    rd = 0;
    check(!ready && !err, "R9 err cleared on accept", {ready, err}, 0);
    while (!ready && n < 200) begin
      if (!rd_ctl || dout != exp_d) bad++;
      if (pump_en) pumped++;
      if (col_en != 16'hFFFF || row_sel != (32'd1 << a)) bad++;
      @(negedge clk);
      n++;
    end
    check(n == RD, "R7 read pulse length", n, RD);
    check(bad == 0, "R8 read data", bad, 0);
    check(pumped == 0, "R7 no pump on read", pumped, 0);
    check(dout == 0 && !rd_ctl, "R8 dout cleared", dout, 0);
  endtask

  task automatic t_rejects();
    int act = 0;
    en = 0; wr = 1;
    @(negedge clk);
    wr = 0; rd = 1;
    @(negedge clk);
    rd = 0; en = 1;
    repeat (3) begin
      if (!ready || erase || rd_ctl) act++;
      @(negedge clk);
    end
    check(act == 0, "R2 ignored while disabled", act, 0);
    rd = 1; wr = 1;
    @(negedge clk);
    rd = 0; wr = 0;
    repeat (3) begin
      if (!ready || erase || rd_ctl || pump_en) act++;
      @(negedge clk);
    end
    check(act == 0, "R2 both commands rejected", act, 0);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_write(5'd3, 16'hA5C3, 5, 0, 0);
    t_write(5'd31, 16'h0001, 1, 1, 0);
    t_write(5'd0, 16'hFFFF, TMO - 1, 0, 0);
    t_write(5'd17, 16'h1234, TMO, 0, 1);
    t_read(5'd9, 0);
    t_read(5'd22, 1);
    t_rejects();
    t_write(5'd12, 16'h8000, 0, 0, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule